// File: doc/BRIEF.md
# SIMD Integer Multiply-by-Scalar Unit

This unit runs one vector integer multiply-by-scalar operation at a time against a private file of 32 registers, each 64 bits wide. A 32-bit instruction word is offered with a valid/ready handshake and decoded in the accepting cycle. At that point the unit captures one scalar element from a lane of a chosen register, along with the source register or register pair. It then multiplies every lane of the captured source by the scalar and writes one 64-bit destination register per cycle. Each result lane keeps only the low element-width bits of the product.

Lanes are 16 or 32 bits wide, depending on the size field. The way the scalar register number and lane index are split across instruction fields depends on that lane width. A wide form covers an aligned pair of registers in two beats. Encodings that are not legal raise a one-cycle undefined flag. Floating-point encodings raise a one-cycle unsupported flag. Neither of these writes to the register file. A separate write port and read port give direct access to the register file, so that operands can be loaded and results inspected.

Top module: `simd_scalar_mul`

## Requirements
- R1: After synchronous active-low reset, all 32 registers read as zero, `in_ready` is 1, and `done`, `undef_flag` and `unsup_flag` are 0.
- R2: The word is recognised when bits [31:25]=1111001, bit 23=1, bits [11:9]=100, bit 6=1 and bit 4=0. Size is bits [21:20]. With size 01, lanes are 16 bits (four per register). The scalar register is {0,0,bits[2:0]} and the lane index is {bit 5, bit 3}. Each result lane is the low 16 bits of source lane times scalar.
- R3: With size 10, lanes are 32 bits (two per register). The scalar register is bits [3:0] and the lane index is bit 5. Each result lane is the low 32 bits of the product.
- R4: The destination is {bit 22, bits[15:12]} and the source is {bit 7, bits[19:16]}. When bit 24 (pair mode) is 0, the destination is written on the first clock edge after acceptance, and `done` is high in the cycle just before that edge.
- R5: When bit 24 is 1, destination d is written from source n on the first edge after acceptance. Destination d+1 is written from source n+1 on the second edge, lane for lane. `done` is high only in the cycle before the second write.
- R6: The scalar and all source lanes are taken from register values as they stood when the instruction was accepted. A destination that overlaps the source or the scalar register therefore still uses the old values.
- R7: `undef_flag` pulses for the one cycle after acceptance, with no register write and no `done`, in these cases: the fixed bits do not match, size is 11, or bit 8 is 0 and either size is 00 or pair mode has bit 12 or bit 16 set.
- R8: If the fixed bits match, size is not 11 and bit 8 is 1, `unsup_flag` pulses for the one cycle after acceptance and no register is written. This takes priority over the size-00 and alignment checks.
- R9: `in_ready` is 0 from the edge that accepts a legal instruction until the last write of that instruction, so no instruction overlaps another.
- R10: `wr_en` writes `wr_data` into register `wr_addr` at the clock edge, unless an instruction writes a register at that same edge, in which case the instruction's write wins. `rd_data` shows register `rd_addr` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction word offered |
| in_instr | input | 32 | Instruction word |
| in_ready | output | 1 | Unit idle and able to accept a word |
| done | output | 1 | High in the cycle of the last register write of an instruction |
| undef_flag | output | 1 | One-cycle pulse for an undefined encoding |
| unsup_flag | output | 1 | One-cycle pulse for a floating-point encoding |
| wr_en | input | 1 | Register file direct write enable |
| wr_addr | input | 5 | Register file direct write address |
| wr_data | input | 64 | Register file direct write data |
| rd_addr | input | 5 | Register file read address |
| rd_data | output | 64 | Register file read data |

## Verification
An undefined or unsupported flag, or the `done` of a single-register instruction, is due in the first cycle after the accepting edge. The `done` of a pair instruction is due one cycle later. For every instruction it issues, the driver records the accepting cycle count and queues the expected event kind with its latency. A monitor samples the outputs on the falling edge and checks both the kind and the cycle offset. Register contents are read back through the read port only after the final write edge has passed, and are compared against a bench model that has been updated from the requirements.

// File: rtl/simd_mul_pkg.sv
// Shared constants and the decoded-operation record for the multiply-by-scalar unit.
// Assumes a 32-entry register file, so register numbers are always 5 bits.
package simd_mul_pkg;
    localparam int REG_NUM_W = 5;

    typedef struct packed {
        logic                 pair;   // two-register form
        logic                 wide;   // 32-bit lanes when set, 16-bit otherwise
        logic [REG_NUM_W-1:0] dst;
        logic [REG_NUM_W-1:0] src;
        logic [REG_NUM_W-1:0] sreg;   // register holding the scalar
        logic [1:0]           lane;   // scalar lane index
    } smul_op_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BEAT0 = 2'd1,
        ST_BEAT1 = 2'd2
    } smul_state_e;
endpackage

// File: rtl/smul_decode.sv
// Combinational decoder for the multiply-by-scalar instruction word.
// Classifies the word as legal, undefined or unsupported (floating point)
// and extracts register numbers and the scalar lane.
// Assumes the caller samples the outputs only when the word is accepted.
module smul_decode
    import simd_mul_pkg::*;
(
    input  logic [31:0] instr,
    output smul_op_t    op,
    output logic        legal,
    output logic        undef,
    output logic        unsup
);
    logic       fixed_ok;
    logic       recog;
    logic       fp_sel;
    logic       misalign;
    logic [1:0] size;

    // Classify the word against the fixed opcode bits and field rules.
    always_comb begin
        size     = instr[21:20];
        fixed_ok = (instr[31:25] == 7'b1111001) && instr[23] &&
                   (instr[11:9] == 3'b100) && instr[6] && !instr[4];
        recog    = fixed_ok && (size != 2'b11);
        fp_sel   = instr[8];
        misalign = instr[24] && (instr[12] || instr[16]);
        unsup    = recog && fp_sel;
        legal    = recog && !fp_sel && (size != 2'b00) && !misalign;
        undef    = !recog || (!fp_sel && ((size == 2'b00) || misalign));
    end

    // Extract operand fields; the scalar split depends on lane width.
    always_comb begin
        op.pair = instr[24];
        op.wide = (instr[21:20] == 2'b10);
        op.dst  = {instr[22], instr[15:12]};
        op.src  = {instr[7], instr[19:16]};
        if (op.wide) begin
            op.sreg = {1'b0, instr[3:0]};
            op.lane = {1'b0, instr[5]};
        end else begin
            op.sreg = {2'b00, instr[2:0]};
            op.lane = {instr[5], instr[3]};
        end
    end
endmodule

// File: rtl/smul_regfile.sv
// Register file with two write ports and NRD combinational read ports.
// Port A (execution) has priority over port B (direct access) on the same edge.
// Cleared to zero on synchronous active-low reset.
module smul_regfile #(
    parameter int NREG  = 32,
    parameter int REG_W = 64,
    parameter int NRD   = 4,
    localparam int AW   = $clog2(NREG)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we_a,
    input  logic [AW-1:0]             wa_a,
    input  logic [REG_W-1:0]          wd_a,
    input  logic                      we_b,
    input  logic [AW-1:0]             wa_b,
    input  logic [REG_W-1:0]          wd_b,
    input  logic [NRD-1:0][AW-1:0]    raddr,
    output logic [NRD-1:0][REG_W-1:0] rdata
);
    logic [REG_W-1:0] mem [NREG];

    // Storage update: reset clear, then execution write, else direct write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) mem[i] <= '0;
        end else if (we_a) begin
            mem[wa_a] <= wd_a;
        end else if (we_b) begin
            mem[wa_b] <= wd_b;
        end
    end

    // One combinational read path per port.
    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rdata[g] = mem[raddr[g]];
    end

    // R10: on a same-edge clash the execution write lands.
    p_port_a_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (we_a && we_b) |=> (mem[$past(wa_a)] == $past(wd_a)));
endmodule

// File: rtl/smul_scalar_pick.sv
// Selects the scalar element out of one register by lane index.
// Narrow (16-bit) scalars are returned zero-extended in the low half.
module smul_scalar_pick #(
    parameter int REG_W = 64,
    localparam int N16  = REG_W / 16,
    localparam int N32  = REG_W / 32
) (
    input  logic [REG_W-1:0] value,
    input  logic [1:0]       lane,
    input  logic             wide,
    output logic [31:0]      scalar
);
    logic [N16-1:0][15:0] half_l;
    logic [N32-1:0][31:0] word_l;

    for (genvar g = 0; g < N16; g++) begin : g_h
        assign half_l[g] = value[g*16 +: 16];
    end
    for (genvar g = 0; g < N32; g++) begin : g_w
        assign word_l[g] = value[g*32 +: 32];
    end

    // Lane select for the active element width.
    always_comb begin
        if (wide) scalar = word_l[lane[0]];
        else      scalar = {16'b0, half_l[lane]};
    end
endmodule

// File: rtl/smul_lanes.sv
// Lane-parallel multiplier: every lane of one register times the scalar,
// keeping the low element-width bits. Both widths are built; wide picks one.
module smul_lanes #(
    parameter int REG_W = 64,
    localparam int N16  = REG_W / 16,
    localparam int N32  = REG_W / 32
) (
    input  logic [REG_W-1:0] src,
    input  logic [31:0]      scalar,
    input  logic             wide,
    output logic [REG_W-1:0] prod
);
    logic [REG_W-1:0] res16;
    logic [REG_W-1:0] res32;

    for (genvar g = 0; g < N16; g++) begin : g_m16
        assign res16[g*16 +: 16] = src[g*16 +: 16] * scalar[15:0];
    end
    for (genvar g = 0; g < N32; g++) begin : g_m32
        assign res32[g*32 +: 32] = src[g*32 +: 32] * scalar;
    end

    // Width selection for the result register.
    always_comb prod = wide ? res32 : res16;
endmodule

// File: rtl/simd_scalar_mul.sv
// Multiply-by-scalar execution unit. Accepts one instruction word at a time,
// snapshots the scalar and the source register(s) on acceptance, then writes
// one destination register per cycle. Illegal and floating-point words only
// raise a one-cycle flag. Assumes the direct write port is used while idle.
module simd_scalar_mul
    import simd_mul_pkg::*;
#(
    parameter int NREG  = 32,
    parameter int REG_W = 64,
    localparam int AW   = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [31:0]      in_instr,
    output logic             in_ready,
    output logic             done,
    output logic             undef_flag,
    output logic             unsup_flag,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [REG_W-1:0] wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [REG_W-1:0] rd_data
);
    smul_op_t              dec_op;
    smul_op_t              op_r;
    logic                  dec_legal, dec_undef, dec_unsup;
    logic                  accept;
    smul_state_e           state;
    logic [31:0]           scal_r;
    logic [31:0]           scal_pick;
    logic [REG_W-1:0]      snap0, snap1;
    logic [REG_W-1:0]      beat_src, beat_prod;
    logic                  ex_we;
    logic [AW-1:0]         ex_wa;
    logic [3:0][AW-1:0]    rf_raddr;
    logic [3:0][REG_W-1:0] rf_rdata;

    smul_decode u_dec (
        .instr (in_instr),
        .op    (dec_op),
        .legal (dec_legal),
        .undef (dec_undef),
        .unsup (dec_unsup)
    );

    // Read ports: 0 direct, 1 scalar, 2 first source, 3 second source.
    always_comb begin
        rf_raddr[0] = rd_addr;
        rf_raddr[1] = dec_op.sreg;
        rf_raddr[2] = dec_op.src;
        rf_raddr[3] = AW'(dec_op.src + 1'b1);
    end

    smul_regfile #(.NREG(NREG), .REG_W(REG_W), .NRD(4)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we_a  (ex_we),
        .wa_a  (ex_wa),
        .wd_a  (beat_prod),
        .we_b  (wr_en),
        .wa_b  (wr_addr),
        .wd_b  (wr_data),
        .raddr (rf_raddr),
        .rdata (rf_rdata)
    );

    assign rd_data = rf_rdata[0];

    smul_scalar_pick #(.REG_W(REG_W)) u_pick (
        .value  (rf_rdata[1]),
        .lane   (dec_op.lane),
        .wide   (dec_op.wide),
        .scalar (scal_pick)
    );

    assign in_ready = (state == ST_IDLE);
    assign accept   = in_valid && in_ready;

    // Sequencer: capture operands on acceptance, then step through beats.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            op_r  <= '0;
            scal_r <= '0;
            snap0 <= '0;
            snap1 <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (accept && dec_legal) begin
                    state  <= ST_BEAT0;
                    op_r   <= dec_op;
                    scal_r <= scal_pick;
                    snap0  <= rf_rdata[2];
                    snap1  <= rf_rdata[3];
                end
                ST_BEAT0: state <= op_r.pair ? ST_BEAT1 : ST_IDLE;
                ST_BEAT1: state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // Flag pulses for rejected words, one cycle after acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            undef_flag <= 1'b0;
            unsup_flag <= 1'b0;
        end else begin
            undef_flag <= accept && dec_undef;
            unsup_flag <= accept && dec_unsup;
        end
    end

    // Beat datapath: which snapshot feeds the multiplier and where it lands.
    always_comb begin
        ex_we    = (state == ST_BEAT0) || (state == ST_BEAT1);
        beat_src = (state == ST_BEAT1) ? snap1 : snap0;
        ex_wa    = (state == ST_BEAT1) ? AW'(op_r.dst + 1'b1) : op_r.dst;
        done     = ((state == ST_BEAT0) && !op_r.pair) || (state == ST_BEAT1);
    end

    smul_lanes #(.REG_W(REG_W)) u_mul (
        .src    (beat_src),
        .scalar (scal_r),
        .wide   (op_r.wide),
        .prod   (beat_prod)
    );

    // R4: a single-register instruction completes in the next cycle.
    p_single_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && dec_legal && !dec_op.pair) |=> (done && ex_we));

    // R5: a pair instruction writes twice, done on the second beat only.
    p_pair_beats_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && dec_legal && dec_op.pair) |=> (ex_we && !done) ##1 (ex_we && done));

    // R7: an undefined word never causes a write or a completion.
    p_undef_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && dec_undef) |=> (!ex_we && !done && undef_flag));

    // R8: a floating-point word never causes a write.
    p_unsup_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && dec_unsup) |=> (!ex_we && unsup_flag && !undef_flag));

    // R9: no new acceptance while beats are outstanding.
    p_busy_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && dec_legal) |=> !in_ready);

    // R7/R8: at most one outcome indication per cycle.
    p_outcome_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, undef_flag, unsup_flag}));
endmodule

// File: tb/simd_scalar_mul_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expected outcome events, a falling-edge
// monitor pops and compares them; register contents come from the read port.
module simd_scalar_mul_tb;
    localparam int K_DONE  = 0;
    localparam int K_UNDEF = 1;
    localparam int K_UNSUP = 2;

    typedef struct {
        int kind;
        int lat;
        int acc;
        string req;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_instr = '0;
    logic        in_ready, done, undef_flag, unsup_flag;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [63:0] wr_data = '0;
    logic [4:0]  rd_addr = '0;
    logic [63:0] rd_data;

    int    n_chk = 0;
    int    n_fail = 0;
    int    cyc = 0;
    bit    finished = 1'b0;
    item_t sb[$];
    logic [63:0] mdl [32];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    simd_scalar_mul u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr),
        .in_ready(in_ready), .done(done), .undef_flag(undef_flag),
        .unsup_flag(unsup_flag), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] enc(input bit q, input bit d, input logic [1:0] sz,
            input logic [3:0] vn, input logic [3:0] vd, input bit f, input bit n,
            input bit m, input logic [3:0] vm);
        return {7'b1111001, q, 1'b1, d, sz, vn, vd, 3'b100, f, n, 1'b1, m, 1'b0, vm};
    endfunction

    function automatic logic [63:0] lanemul(input logic [63:0] s, input logic [31:0] k,
                                            input bit wide);
        logic [63:0] r;
        if (wide) begin
            for (int i = 0; i < 2; i++) r[i*32 +: 32] = s[i*32 +: 32] * k;
        end else begin
            for (int i = 0; i < 4; i++) r[i*16 +: 16] = s[i*16 +: 16] * k[15:0];
        end
        return r;
    endfunction

    // Monitor: every outcome indication must match the head of the queue.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (done || undef_flag || unsup_flag) begin
                int k;
                k = done ? K_DONE : (undef_flag ? K_UNDEF : K_UNSUP);
                if (sb.size() == 0) begin
                    chk(1'b0, "R9", "unexpected outcome", 64'(k), 64'hff);
                end else begin
                    item_t it;
                    it = sb.pop_front();
                    chk(k == it.kind, it.req, "outcome kind", 64'(k), 64'(it.kind));
                    chk((cyc - it.acc) == it.lat, it.req, "outcome cycle",
                        64'(cyc - it.acc), 64'(it.lat));
                end
            end
        end
    end

    task automatic wr_reg(input int a, input logic [63:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 5'(a); wr_data = v;
        @(posedge clk); #1;
        wr_en = 1'b0;
        mdl[a] = v;
    endtask

    task automatic check_regs(input string req);
        for (int i = 0; i < 32; i++) begin
            rd_addr = 5'(i);
            #0.5;
            chk(rd_data === mdl[i], req, $sformatf("reg %0d", i), rd_data, mdl[i]);
        end
    endtask

    // Driver: issue one word, predict outcome and register effect.
    task automatic issue(input logic [31:0] w, input string req);
        bit fixed_ok, recog, fp, mis, legal, undef, q, wide;
        logic [1:0] sz;
        int d, n, m, idx, acc;
        logic [31:0] k;
        logic [63:0] o0, o1;
        item_t it;
        sz = w[21:20]; q = w[24]; fp = w[8];
        fixed_ok = (w[31:25] == 7'b1111001) && w[23] && (w[11:9] == 3'b100) && w[6] && !w[4];
        recog = fixed_ok && (sz != 2'b11);
        mis = q && (w[12] || w[16]);
        legal = recog && !fp && sz != 2'b00 && !mis;
        undef = !recog || (!fp && (sz == 2'b00 || mis));
        @(negedge clk);
        chk(in_ready === 1'b1, "R9", "ready before issue", 64'(in_ready), 64'd1);
        in_valid = 1'b1; in_instr = w;
        @(posedge clk); #1;
        acc = cyc;
        it.acc = acc; it.req = req;
        if (legal)      begin it.kind = K_DONE;  it.lat = q ? 1 : 0; end
        else if (undef) begin it.kind = K_UNDEF; it.lat = 0; end
        else            begin it.kind = K_UNSUP; it.lat = 0; end
        sb.push_back(it);
        @(negedge clk);
        in_valid = 1'b0;
        if (legal)
            chk(in_ready === 1'b0, "R9", "ready low while busy", 64'(in_ready), 64'd0);
        if (legal) begin
            wide = (sz == 2'b10);
            d = {w[22], w[15:12]};
            n = {w[7], w[19:16]};
            m = wide ? int'(w[3:0]) : int'(w[2:0]);
            idx = wide ? int'(w[5]) : int'({w[5], w[3]});
            k = wide ? mdl[m][idx*32 +: 32] : {16'b0, mdl[m][idx*16 +: 16]};
            o0 = mdl[n];
            o1 = mdl[(n + 1) % 32];
            mdl[d] = lanemul(o0, k, wide);
            if (q) mdl[(d + 1) % 32] = lanemul(o1, k, wide);
        end
        repeat (3) @(negedge clk);
        chk(sb.size() == 0, req, "outcome seen", 64'(sb.size()), 64'd0);
        check_regs(req);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] v;
        for (int i = 0; i < 32; i++) mdl[i] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state.
        chk(in_ready === 1'b1, "R1", "ready", 64'(in_ready), 64'd1);
        chk({done, undef_flag, unsup_flag} === 3'b000, "R1", "flags",
            64'({done, undef_flag, unsup_flag}), 64'd0);
        check_regs("R1");
        // R10: load every register through the direct port.
        v = 64'h0123_4567_89ab_cdef;
        for (int i = 0; i < 32; i++) begin
            v = v * 64'd6364136223846793005 + 64'd1442695040888963407;
            wr_reg(i, v);
        end
        wr_reg(3, 64'hffff_8000_0002_7fff);
        wr_reg(5, 64'h0003_fffe_0010_ffff);
        check_regs("R10");
        // R2: 16-bit lanes, every scalar lane index.
        issue(enc(0, 0, 2'b01, 4'd4, 4'd8, 0, 0, 0, 4'd3), "R2");
        issue(enc(0, 0, 2'b01, 4'd3, 4'd9, 0, 0, 0, 4'd13), "R2");
        issue(enc(0, 1, 2'b01, 4'd5, 4'd2, 0, 1, 1, 4'd5), "R2");
        issue(enc(0, 0, 2'b01, 4'd6, 4'd10, 0, 0, 1, 4'd15), "R2");
        // R3: 32-bit lanes, both indices, scalar register above 7.
        issue(enc(0, 0, 2'b10, 4'd3, 4'd11, 0, 0, 0, 4'd12), "R3");
        issue(enc(0, 1, 2'b10, 4'd7, 4'd14, 0, 1, 1, 4'd5), "R3");
        // R4: destination with high bit, source with high bit.
        issue(enc(0, 1, 2'b10, 4'd1, 4'd15, 0, 1, 0, 4'd9), "R4");
        // R5: pair forms in both widths.
        issue(enc(1, 0, 2'b01, 4'd4, 4'd12, 0, 0, 1, 4'd11), "R5");
        issue(enc(1, 1, 2'b10, 4'd2, 4'd6, 0, 1, 1, 4'd3), "R5");
        // R6: overlap of destination with source and with scalar register.
        issue(enc(1, 0, 2'b01, 4'd2, 4'd2, 0, 0, 0, 4'd3), "R6");
        issue(enc(0, 0, 2'b10, 4'd5, 4'd5, 0, 0, 1, 4'd5), "R6");
        // R7: undefined words.
        issue(enc(0, 0, 2'b00, 4'd1, 4'd2, 0, 0, 0, 4'd3), "R7");
        issue(enc(0, 0, 2'b11, 4'd1, 4'd2, 0, 0, 0, 4'd3), "R7");
        issue(enc(1, 0, 2'b01, 4'd2, 4'd3, 0, 0, 0, 4'd3), "R7");
        issue(enc(1, 0, 2'b10, 4'd3, 4'd2, 0, 0, 0, 4'd3), "R7");
        issue(enc(0, 0, 2'b01, 4'd1, 4'd2, 0, 0, 0, 4'd3) & ~32'h0080_0000, "R7");
        issue(enc(0, 0, 2'b01, 4'd1, 4'd2, 0, 0, 0, 4'd3) | 32'h0000_0010, "R7");
        // R8: floating point, including with size 00 and misaligned pair.
        issue(enc(0, 0, 2'b10, 4'd1, 4'd2, 1, 0, 0, 4'd3), "R8");
        issue(enc(1, 0, 2'b00, 4'd1, 4'd3, 1, 0, 0, 4'd3), "R8");
        // R9: back-to-back legal pair after a flag.
        issue(enc(1, 1, 2'b01, 4'd8, 4'd0, 0, 0, 1, 4'd7), "R9");
        // R10: direct write while an instruction writes the same register.
        @(negedge clk);
        in_valid = 1'b1;
        in_instr = enc(0, 0, 2'b10, 4'd1, 4'd4, 0, 0, 0, 4'd2);
        @(posedge clk); #1;
        begin
            item_t it;
            it.kind = K_DONE; it.lat = 0; it.acc = cyc; it.req = "R10";
            sb.push_back(it);
        end
        @(negedge clk);
        in_valid = 1'b0;
        wr_en = 1'b1; wr_addr = 5'd4; wr_data = 64'hdead_beef_dead_beef;
        mdl[4] = lanemul(mdl[1], mdl[2][31:0], 1'b1);
        @(posedge clk); #1;
        wr_en = 1'b0;
        repeat (2) @(negedge clk);
        check_regs("R10");
        finished = 1'b1;
        chk(sb.size() == 0, "R9", "queue drained", 64'(sb.size()), 64'd0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule